// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache that sits between a processor port and a slower word-wide memory port. It holds `LINES` lines of `LINE_BYTES` bytes each. Each line has one possible home, chosen from the low-order bits of the block address. For every line the block keeps a valid flag and the upper address bits (the tag). A load that finds its line valid with a matching tag is answered in the cycle it is presented. A load that misses holds the processor off and fetches the whole line from memory as a burst. The load is then answered out of the refreshed line.

Every store is written through to memory. Stores do not wait for memory: they are posted into a small first-in first-out store queue that drains to memory on its own. A store that hits also updates the cached word. A store that misses leaves the cache untouched and allocates no line. The processor waits on a store only when the queue is full. Before a line fetch is issued, the queue is emptied, so a fill can never bring back a word that an older posted store has not yet reached.

The processor side holds `cpu_req`, together with its address, write flag and data, until `cpu_ack` is sampled high at a clock edge. The memory side issues one request at a time with a valid/ready handshake. A fill request (`mem_req_we` low) is answered by exactly one `mem_rsp_valid` beat per word of the line.

Top module: `dmwt_cache`

## Requirements
- R1: With default parameters (64 lines, 16-byte lines, 32-bit addresses), byte offset is address bits 3:0, word select is bits 3:2, line index is bits 9:4 and tag is bits 31:10. Address 1200 therefore lives in line 11. An address differing only above bit 9 (such as 2224) maps to the same line and replaces it.
- R2: Reset clears every valid flag, so the first load after reset misses. Right after reset `cpu_ack` and `mem_req_valid` are low.
- R3: A load to a valid line with a matching tag is acknowledged in the cycle it is presented, with the addressed word on `cpu_rdata`, and issues no memory read.
- R4: A load miss keeps `cpu_ack` low and issues one read request whose address is the miss address with its low 4 bits cleared. It accepts one beat per word, word 0 first, and then acknowledges with the requested word.
- R5: A load miss issues its fill request only once the store queue is empty, so it returns data written by earlier stores.
- R6: A store that hits updates the cached word, is acknowledged in the same cycle while the queue has room, and queues a memory write of its address and data.
- R7: A store that misses is acknowledged and queued but allocates no line. A later load to that address misses.
- R8: With `WB_DEPTH` (4) stores pending, a further store is not acknowledged until an entry has been accepted by memory.
- R9: Queued stores reach memory in issue order, as requests with `mem_req_we` high carrying the stored address and data.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, data and write flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = posted write, 0 = line fill |
| mem_req_addr | output | ADDR_W | Write address, or line-aligned fill address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | One fill word is present |
| mem_rsp_data | input | DATA_W | Fill word, line word 0 first |

## Verification
The bench sends two addresses that share line 11 but have different tags. A design that slices the index or tag wrongly either hits where it should refill, or misses on a line it just loaded. A store miss is read back at once. A design that allocates on a store miss reports no fill and returns an unfilled line. A design that fills before the queue drains returns the memory value from before the store. With memory held not ready, the queue is filled to its depth. A queue that overflows or mis-orders drops or reorders stores in the write log. A request that changes while it waits shows up as a different head address before acceptance. A fill that places beats in the wrong word slots fails the hit reads of later words in the line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FREQ  = 2'd2,
    ST_FILL  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/dmc_wbuf.sv
// Posted store queue: first in, first out, fixed depth.
module dmc_wbuf #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [PW:0]   cnt_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (PW+1)'(DEPTH));
  assign dout  = slot_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  wb_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9
  wb_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dmc_lines.sv
// Tag, valid and data storage for all lines, with combinational lookup.
module dmc_lines #(
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [WSEL_W-1:0] lk_word,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_valid,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  set_tag
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << WSEL_W;

  logic [DATA_W-1:0] data_q [LINES][WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  assign lk_tag   = tag_q[lk_idx];
  assign lk_valid = valid_q[lk_idx];
  assign lk_data  = data_q[lk_idx][lk_word];

  always_ff @(posedge clk) begin
    if (wr_en)  data_q[wr_idx][wr_word] <= wr_data;
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      valid_q <= '0;
    else if (set_en) valid_q[set_idx] <= 1'b1;
  end
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_BYTES = 16,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int IDX_W      = $clog2(LINES);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int ENT_W      = ADDR_W + DATA_W;

  // Address arithmetic
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] wsel_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [WSEL_W-1:0] beat_q;

  // Lookup
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_valid;
  logic [DATA_W-1:0] lk_data;
  logic              in_idle;
  logic              lookup_hit;

  // Named events
  logic rd_hit_ack, rd_miss, wr_accept, wr_hit;
  logic fill_req, fill_beat, fill_last;

  // Store queue
  logic             wb_empty, wb_full, wb_pop;
  logic [ENT_W-1:0] wb_head;

  // Line storage write port
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [WSEL_W-1:0] st_wr_word;
  logic [DATA_W-1:0] st_wr_data;

  logic unused_bits;
  assign unused_bits = ^{cpu_addr[BSEL_W-1:0], miss_addr_q[OFF_W-1:0]};

  assign in_idle    = (state_q == ST_IDLE);
  assign lookup_hit = lk_valid && (lk_tag == tag_of(cpu_addr));

  assign rd_hit_ack = in_idle && cpu_req && !cpu_we && lookup_hit;
  assign rd_miss    = in_idle && cpu_req && !cpu_we && !lookup_hit;
  assign wr_accept  = in_idle && cpu_req && cpu_we && !wb_full;
  assign wr_hit     = wr_accept && lookup_hit;
  assign fill_req   = (state_q == ST_FREQ);
  assign fill_beat  = (state_q == ST_FILL) && mem_rsp_valid;
  assign fill_last  = fill_beat && (beat_q == WSEL_W'(WORDS - 1));

  assign cpu_ack   = rd_hit_ack || wr_accept;
  assign cpu_rdata = lk_data;

  dmc_lines #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W),
    .WSEL_W(WSEL_W),
    .DATA_W(DATA_W)
  ) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (idx_of(cpu_addr)),
    .lk_word (wsel_of(cpu_addr)),
    .lk_tag  (lk_tag),
    .lk_valid(lk_valid),
    .lk_data (lk_data),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_word (st_wr_word),
    .wr_data (st_wr_data),
    .set_en  (fill_last),
    .set_idx (idx_of(miss_addr_q)),
    .set_tag (tag_of(miss_addr_q))
  );

  always_comb begin
    st_wr_en = wr_hit || fill_beat;
    if (fill_beat) begin
      st_wr_idx  = idx_of(miss_addr_q);
      st_wr_word = beat_q;
      st_wr_data = mem_rsp_data;
    end else begin
      st_wr_idx  = idx_of(cpu_addr);
      st_wr_word = wsel_of(cpu_addr);
      st_wr_data = cpu_wdata;
    end
  end

  dmc_wbuf #(
    .W    (ENT_W),
    .DEPTH(WB_DEPTH)
  ) u_wbuf (
    .clk  (clk),
    .rst_n(rst_n),
    .push (wr_accept),
    .din  ({cpu_addr, cpu_wdata}),
    .pop  (wb_pop),
    .dout (wb_head),
    .empty(wb_empty),
    .full (wb_full)
  );

  // Memory request: a fill has the port to itself (queue is empty then)
  assign mem_req_valid = fill_req || !wb_empty;
  assign mem_req_we    = !fill_req;
  assign mem_req_addr  = fill_req ? line_base(miss_addr_q) : wb_head[ENT_W-1 -: ADDR_W];
  assign mem_req_wdata = fill_req ? '0 : wb_head[DATA_W-1:0];
  assign wb_pop        = !fill_req && !wb_empty && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      miss_addr_q <= '0;
      beat_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (rd_miss) begin
          miss_addr_q <= cpu_addr;
          state_q     <= ST_DRAIN;
        end
        ST_DRAIN: if (wb_empty) state_q <= ST_FREQ;
        ST_FREQ: if (mem_req_ready) begin
          beat_q  <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (fill_beat) begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  fill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> wb_empty);
  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));
  // R3
  hit_no_mem_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_ack |-> !(mem_req_valid && !mem_req_we));
  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !cpu_ack);
  // R4
  rsp_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state_q == ST_FILL));
  // R7
  wr_miss_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !lookup_hit) |=> (state_q == ST_IDLE));
endmodule

// File: tb/dmwt_cache_tb.sv
module dmwt_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  always #5 clk = ~clk;

  dmwt_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0;

  function automatic logic [31:0] initf(input int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0003);
  endfunction

  // Memory model and expected memory image
  logic [31:0] mem     [0:4095];
  logic [31:0] ref_mem [0:4095];
  logic [31:0] wl_addr [0:63];
  logic [31:0] wl_data [0:63];
  logic [31:0] ew_addr [0:63];
  logic [31:0] ew_data [0:63];
  int          wl_n = 0, ew_n = 0, fill_n = 0, fill_snap = 0;
  logic [31:0] fill_addr = '0;
  logic        ready_en = 1'b1;
  int          left = 0, bidx = 0;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;

  assign mem_req_ready = ready_en;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = initf(i);
      ref_mem[i] = initf(i);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_v <= 1'b0;
      left  <= 0;
    end else begin
      if (left != 0) begin
        rsp_v <= 1'b1;
        rsp_d <= mem[bidx];
        bidx  <= bidx + 1;
        left  <= left - 1;
      end else rsp_v <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[13:2]] <= mem_req_wdata;
          wl_addr[wl_n] <= mem_req_addr;
          wl_data[wl_n] <= mem_req_wdata;
          wl_n <= wl_n + 1;
        end else begin
          left      <= 4;
          bidx      <= int'(mem_req_addr[13:2]);
          fill_n    <= fill_n + 1;
          fill_addr <= mem_req_addr;
          fill_snap <= wl_n;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cpu_start(input logic we, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (we) begin
      ref_mem[a[13:2]] = d;
      ew_addr[ew_n] = a; ew_data[ew_n] = d; ew_n++;
    end
  endtask

  task automatic cpu_wait(output logic [31:0] rd, output int stalls);
    stalls = 0;
    rd = '0;
    forever begin
      #1;
      if (cpu_ack) begin rd = cpu_rdata; break; end
      @(negedge clk);
      stalls++;
      if (stalls > 500) break;
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic drain_wait();
    for (int i = 0; i < 40; i++) @(negedge clk);
  endtask

  // we, addr, wdata, expect stall, expect fill
  localparam logic [66:0] VEC [0:11] = '{
    {1'b0, 32'd1200,       32'h0,          1'b1, 1'b1},
    {1'b0, 32'd1204,       32'h0,          1'b0, 1'b0},
    {1'b0, 32'd1212,       32'h0,          1'b0, 1'b0},
    {1'b1, 32'd1204,       32'h1111_2222,  1'b0, 1'b0},
    {1'b0, 32'd1204,       32'h0,          1'b0, 1'b0},
    {1'b0, 32'd2224,       32'h0,          1'b1, 1'b1},
    {1'b0, 32'd1200,       32'h0,          1'b1, 1'b1},
    {1'b1, 32'h0000_3000,  32'hDEAD_0001,  1'b0, 1'b0},
    {1'b0, 32'h0000_3000,  32'h0,          1'b1, 1'b1},
    {1'b0, 32'h0000_300C,  32'h0,          1'b0, 1'b0},
    {1'b1, 32'h0000_300C,  32'h0BAD_F00D,  1'b0, 1'b0},
    {1'b0, 32'h0000_300C,  32'h0,          1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int st, f0, w0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R2: reset state
    chk(cpu_ack == 1'b0, "R2 ack after reset", {31'b0, cpu_ack}, 32'd0);
    chk(mem_req_valid == 1'b0, "R2 no request after reset", {31'b0, mem_req_valid}, 32'd0);

    // Table walk: R1 R2 R3 R4 R6 R7 (index of 1200 is 11, 2224 shares it)
    for (int v = 0; v < 12; v++) begin
      f0 = fill_n;
      cpu_start(VEC[v][66], VEC[v][65:34], VEC[v][33:2]);
      cpu_wait(rd, st);
      @(negedge clk);
      chk((st > 0) == VEC[v][1], "R3/R4/R6/R7 stall", st, {31'b0, VEC[v][1]});
      chk((fill_n - f0) == int'(VEC[v][0]), "R1/R2/R4/R7 fill count", fill_n - f0, {31'b0, VEC[v][0]});
      if (VEC[v][0])
        chk(fill_addr == {VEC[v][61:38], 4'h0}, "R4 fill line address", fill_addr, {VEC[v][61:38], 4'h0});
      if (!VEC[v][66])
        chk(rd == ref_mem[VEC[v][47:36]], "R3/R4/R5 load data", rd, ref_mem[VEC[v][47:36]]);
    end
    drain_wait();

    // R8/R10: queue full with memory not ready
    ready_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cpu_start(1'b1, 32'h100 + 32'(i * 4), 32'hC0DE_0000 + 32'(i));
      cpu_wait(rd, st);
      chk(st == 0, "R8 store with room", st, 32'd0);
    end
    cpu_start(1'b1, 32'h200, 32'hC0DE_0004);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(cpu_ack == 1'b0, "R8 full queue stalls", {31'b0, cpu_ack}, 32'd0);
      chk(mem_req_addr == 32'h100, "R10 head held", mem_req_addr, 32'h100);
      @(negedge clk);
    end
    ready_en = 1'b1;
    cpu_wait(rd, st);
    chk(st > 0, "R8 released after drain", st, 32'd1);
    drain_wait();

    // R5: read miss behind a pending store
    ready_en = 1'b0;
    cpu_start(1'b1, 32'h2000, 32'h7777_1234);
    cpu_wait(rd, st);
    f0 = fill_n;
    cpu_start(1'b0, 32'h2000, 32'h0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(fill_n == f0, "R5 no fill while queue busy", fill_n, f0);
    w0 = wl_n;
    ready_en = 1'b1;
    cpu_wait(rd, st);
    chk(rd == 32'h7777_1234, "R5 fresh data after drain", rd, 32'h7777_1234);
    chk(fill_snap == w0 + 1, "R5 fill follows store", fill_snap, w0 + 1);
    drain_wait();

    // R9: write log order
    chk(wl_n == ew_n, "R9 write count", wl_n, ew_n);
    for (int i = 0; i < ew_n; i++) begin
      chk(wl_addr[i] == ew_addr[i], "R9 write address order", wl_addr[i], ew_addr[i]);
      chk(wl_data[i] == ew_data[i], "R9 write data order", wl_data[i], ew_data[i]);
    end
    finish_run();
  end
endmodule